// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial memory. The serial clock and data lines are oversampled by the system clock, passed through a short synchroniser, and watched for start and stop conditions. After a start, the block collects a device byte. It answers only when the upper nibble is the fixed family code and the next three bits equal the three strap inputs. That lets up to eight such slaves share one bus.

A write transfer carries two address bytes, high byte first, that load an internal byte pointer. Each data byte that follows is stored through a single-byte memory port, and the pointer steps after each one. A read transfer streams bytes out from the pointer for as long as the master acknowledges them. A repeated start after the address bytes turns a write header into a random read.

The block only ever pulls the data line low; it never drives it high. The write-protect input stops all data storage. When a write transfer ends, a commit strobe tells the memory to start its write cycle. While the memory reports busy, the block refuses to acknowledge its device byte.

Top module: `i2cs_eeprom_slave`

## Requirements
- R1: While reset is held and at its release, `sda_oe`, `mem_we`, `mem_re` and `mem_commit` are all low.
- R2: Until a start condition (data falls while clock is high) has been seen, clocked bytes get no acknowledge and cause no memory access.
- R3: A device byte with bits 7..4 = 1010 and bits 3..1 equal to `strap[2:0]` is acknowledged by pulling data low during the ninth clock. Bit 0 selects read (1) or write (0).
- R4: A device byte with a different prefix or strap value is not acknowledged. All later bytes are ignored until the next start.
- R5: In a write, two address bytes follow the device byte, high byte first, and form a 14-bit pointer; the top two bits of the high byte are ignored. Each address byte is acknowledged. Each data byte is acknowledged and written at the pointer, which then increments.
- R6: A stop condition (data rises while clock is high) that ends a transfer in which at least one byte was stored produces exactly one `mem_commit` pulse. A transfer that stored nothing produces none.
- R7: While `mem_busy` is high, a matching device byte is not acknowledged.
- R8: In a read, bytes come out most significant bit first, starting at the pointer. The pointer advances once per byte sent, so a later read with no address continues from where the previous one stopped.
- R9: When the master leaves data high on the ninth clock of a read byte, the slave stops driving the line and ignores clocks until the next start or stop.
- R10: While `wp` is high, data bytes of a write are neither acknowledged nor stored. Device and address bytes are still acknowledged.
- R11: The pointer wraps from 0x3FFF to 0x0000.
- R12: `sda_oe` changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 = pull data line low, 0 = release |
| strap | input | 3 | Device select straps |
| wp | input | 1 | Write protect, active high |
| mem_addr | output | 14 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe; data expected on the next cycle |
| mem_rdata | input | 8 | Memory read data |
| mem_commit | output | 1 | One-cycle pulse to start the write cycle |
| mem_busy | input | 1 | Memory write cycle in progress |

## Verification
The hardest case to reach is a read sequence that crosses modes. The bench uses a write header to set the pointer, issues a repeated start into a read, acknowledges two bytes and refuses the third, then clocks a fourth byte. The slave must leave the line released for that fourth byte. A later address-less read must then resume one past the refused byte. The bench builds this from an open-drain model of the line and a small memory model, and it also checks that no write protect or busy refusal leaves a stray strobe or commit behind.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;
    localparam int         BYTE_W     = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDATA,
        ST_RDATA,
        ST_WAIT
    } slv_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] strap);
        return (b[7:4] == DEV_PREFIX) && (b[3:1] == strap);
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] prv;

    assign raw = {scl_i, sda_i};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign lvl[g] = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prv <= '1;
        else     prv <= lvl;
    end

    assign ev = '{
        scl:      lvl[1],
        sda:      lvl[0],
        scl_rise: lvl[1] & ~prv[1],
        scl_fall: ~lvl[1] & prv[1],
        start:    lvl[1] & prv[1] & prv[0] & ~lvl[0],
        stop:     lvl[1] & prv[1] & ~prv[0] & lvl[0]
    };

    // start and stop can never be flagged together
    p_start_stop_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(ev.start && ev.stop));

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
    import i2cs_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [2:0]        strap,
    input  logic              wp,
    input  logic              mem_busy,
    input  logic [7:0]        mem_rdata,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic              mem_commit
);
    localparam int HI_W = ADDR_W - BYTE_W;

    slv_state_e        state;
    logic [3:0]        cnt;
    logic [7:0]        sh;
    logic [7:0]        tx;
    logic [HI_W-1:0]   ahi;
    logic [ADDR_W-1:0] ptr;
    logic              rw;
    logic              mack;
    logic              fetch;
    logic              rd_cap;
    logic              dirty;
    logic              active;

    assign active = (state != ST_IDLE) && (state != ST_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            sh         <= '0;
            tx         <= '1;
            ahi        <= '0;
            ptr        <= '0;
            rw         <= 1'b0;
            mack       <= 1'b0;
            fetch      <= 1'b0;
            rd_cap     <= 1'b0;
            dirty      <= 1'b0;
            sda_oe     <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
            mem_we     <= 1'b0;
            mem_re     <= 1'b0;
            mem_commit <= 1'b0;
        end else begin
            mem_we     <= 1'b0;
            mem_re     <= 1'b0;
            mem_commit <= 1'b0;
            rd_cap     <= mem_re;
            if (fetch) begin
                mem_re   <= 1'b1;
                mem_addr <= ptr;
                fetch    <= 1'b0;
            end

            if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                cnt    <= '0;
                if (dirty) begin
                    mem_commit <= 1'b1;
                    dirty      <= 1'b0;
                end
            end else if (ev.start) begin
                state  <= ST_DEV;
                sda_oe <= 1'b0;
                cnt    <= '0;
            end else if (active) begin
                if (ev.scl_rise) begin
                    if (cnt < 4'd8) begin
                        sh  <= {sh[6:0], ev.sda};
                        cnt <= cnt + 4'd1;
                    end else if (cnt == 4'd8) begin
                        cnt <= 4'd9;
                        if (state == ST_RDATA) begin
                            ptr  <= ptr + 1'b1;
                            mack <= !ev.sda;
                            if (!ev.sda) fetch <= 1'b1;
                        end
                    end
                end else if (ev.scl_fall) begin
                    if (cnt == 4'd8) begin
                        unique case (state)
                            ST_DEV: begin
                                if (dev_hit(sh, strap) && !mem_busy) begin
                                    sda_oe <= 1'b1;
                                    rw     <= sh[0];
                                    if (sh[0]) fetch <= 1'b1;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end
                            ST_AHI: begin
                                sda_oe <= 1'b1;
                                ahi    <= sh[HI_W-1:0];
                            end
                            ST_ALO: begin
                                sda_oe <= 1'b1;
                                ptr    <= {ahi, sh};
                            end
                            ST_WDATA: begin
                                if (!wp) begin
                                    sda_oe    <= 1'b1;
                                    mem_we    <= 1'b1;
                                    mem_addr  <= ptr;
                                    mem_wdata <= sh;
                                    ptr       <= ptr + 1'b1;
                                    dirty     <= 1'b1;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (cnt == 4'd9) begin
                        cnt <= '0;
                        unique case (state)
                            ST_DEV: begin
                                if (rw) begin
                                    state  <= ST_RDATA;
                                    sda_oe <= ~tx[7];
                                end else begin
                                    state  <= ST_AHI;
                                    sda_oe <= 1'b0;
                                end
                            end
                            ST_AHI: begin
                                state  <= ST_ALO;
                                sda_oe <= 1'b0;
                            end
                            ST_ALO: begin
                                state  <= ST_WDATA;
                                sda_oe <= 1'b0;
                            end
                            ST_RDATA: begin
                                if (mack) begin
                                    sda_oe <= ~tx[7];
                                end else begin
                                    state  <= ST_WAIT;
                                    sda_oe <= 1'b0;
                                end
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (state == ST_RDATA && cnt != 4'd0) begin
                        sda_oe <= ~tx[6];
                        tx     <= {tx[6:0], 1'b1};
                    end
                end
            end

            if (rd_cap) tx <= mem_rdata;
        end
    end

    p_idle_released_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_WAIT) |-> !sda_oe);

    p_store_needs_wp_low_r10: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(!wp));

    p_commit_on_stop_r6: assert property (@(posedge clk) disable iff (rst)
        mem_commit |-> $past(ev.stop));

    p_busy_refuses_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEV && ev.scl_fall && cnt == 4'd8 && mem_busy && !ev.start && !ev.stop)
        |=> (!sda_oe && state == ST_WAIT));

    p_oe_moves_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !$past(ev.start || ev.stop)) |-> $past(!ev.scl));

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

endmodule

// File: rtl/i2cs_eeprom_slave.sv
module i2cs_eeprom_slave
    import i2cs_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        strap,
    input  logic              wp,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata,
    output logic              mem_commit,
    input  logic              mem_busy
);
    bus_ev_t ev;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .strap      (strap),
        .wp         (wp),
        .mem_busy   (mem_busy),
        .mem_rdata  (mem_rdata),
        .sda_oe     (sda_oe),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .mem_commit (mem_commit)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!sda_oe && !mem_we && !mem_re && !mem_commit));

endmodule

// File: tb/sim_i2cs_eeprom_slave.sv
module sim_i2cs_eeprom_slave;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic        wp = 1'b0;
    logic        tb_busy = 1'b0;
    logic        sda_oe;
    logic [13:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, mem_re, mem_commit;
    logic [7:0]  mem_rdata = 8'h00;
    logic        sda_line;

    logic [7:0]  mem [64];
    logic [13:0] we_log [16];
    int          we_n = 0;
    int          commit_n = 0;
    int          nchk = 0;
    int          nerr = 0;
    int          viol = 0;
    logic        prev_oe = 1'b0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2cs_eeprom_slave u0 (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap(strap), .wp(wp), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .mem_commit(mem_commit), .mem_busy(tb_busy)
    );

    initial for (int i = 0; i < 64; i++) mem[i] = 8'(i) ^ 8'h5c;

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[5:0]] <= mem_wdata;
            if (we_n < 16) we_log[we_n] <= mem_addr;
            we_n <= we_n + 1;
        end
        if (mem_re) mem_rdata <= mem[mem_addr[5:0]];
        if (mem_commit) commit_n <= commit_n + 1;
    end

    // R12 monitor: the pull-down may only move while the master holds clock low
    always @(negedge clk) begin
        if (!rst && sda_oe !== prev_oe && m_scl) viol++;
        prev_oe = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start;
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop;
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2 * Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        ack = !sda_line;
        wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); m_scl = 1'b1; wq(Q); d[i] = sda_line; wq(Q); m_scl = 1'b0; wq(Q);
        end
        m_sda = !give_ack; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    task automatic t_reset;
        rst = 1'b1; wq(10);
        chk("R1 oe in reset", sda_oe, 0);
        chk("R1 strobes in reset", {mem_we, mem_re, mem_commit}, 0);
        rst = 1'b0; wq(4);
        chk("R1 oe after reset", sda_oe, 0);
        chk("R1 no writes", we_n, 0);
    endtask

    task automatic t_no_start;
        logic a;
        wbyte(8'hAA, a);
        chk("R2 no ack without start", a, 0);
        chk("R2 no access without start", we_n, 0);
    endtask

    task automatic t_match;
        logic a;
        i2c_start; wbyte(8'hAA, a); chk("R3 matching device byte acked", a, 1); i2c_stop;
        i2c_start; wbyte(8'hA6, a); chk("R4 wrong strap refused", a, 0);
        wbyte(8'h00, a); chk("R4 later byte ignored", a, 0); i2c_stop;
        i2c_start; wbyte(8'hBA, a); chk("R4 wrong prefix refused", a, 0); i2c_stop;
        chk("R6 no commit without data", commit_n, 0);
    endtask

    task automatic t_write;
        logic a0, a1, a2, d0, d1, d2;
        i2c_start; wbyte(8'hAA, a0); wbyte(8'h00, a1); wbyte(8'h10, a2);
        chk("R5 header acked", {a0, a1, a2}, 3'b111);
        wbyte(8'h11, d0); wbyte(8'h22, d1); wbyte(8'h33, d2);
        chk("R5 data acked", {d0, d1, d2}, 3'b111);
        i2c_stop; wq(4);
        chk("R5 three stores", we_n, 3);
        chk("R5 store addresses", {we_log[0], we_log[1], we_log[2]}, {14'h10, 14'h11, 14'h12});
        chk("R5 stored data", {mem[16], mem[17], mem[18]}, 24'h112233);
        chk("R6 one commit", commit_n, 1);
    endtask

    task automatic t_busy;
        logic a;
        tb_busy = 1'b1;
        i2c_start; wbyte(8'hAA, a); chk("R7 refused while busy", a, 0); i2c_stop;
        tb_busy = 1'b0;
        i2c_start; wbyte(8'hAA, a); chk("R7 acked when idle", a, 1); i2c_stop;
    endtask

    task automatic t_read;
        logic a, a2;
        logic [7:0] d;
        i2c_start; wbyte(8'hAA, a); wbyte(8'h00, a); wbyte(8'h11, a);
        i2c_start; wbyte(8'hAB, a2); chk("R3 read device byte acked", a2, 1);
        rbyte(1'b1, d); chk("R8 first read byte", d, 8'h22);
        rbyte(1'b1, d); chk("R8 second read byte", d, 8'h33);
        rbyte(1'b0, d); chk("R8 third read byte", d, 8'h13 ^ 8'h5c);
        rbyte(1'b1, d); chk("R9 line released after refusal", d, 8'hFF);
        i2c_stop;
        i2c_start; wbyte(8'hAB, a); rbyte(1'b0, d);
        chk("R8 address-less read continues", d, 8'h14 ^ 8'h5c);
        i2c_stop;
    endtask

    task automatic t_wp;
        logic a0, a1, a2, d0;
        int w0, c0;
        w0 = we_n; c0 = commit_n;
        wp = 1'b1;
        i2c_start; wbyte(8'hAA, a0); wbyte(8'h00, a1); wbyte(8'h20, a2);
        chk("R10 header still acked", {a0, a1, a2}, 3'b111);
        wbyte(8'h77, d0); chk("R10 data refused", d0, 0);
        i2c_stop; wq(4);
        wp = 1'b0;
        chk("R10 no store", we_n, w0);
        chk("R10 memory unchanged", mem[32], 8'h20 ^ 8'h5c);
        chk("R10 no commit", commit_n, c0);
    endtask

    task automatic t_wrap;
        logic a;
        int w0;
        w0 = we_n;
        i2c_start; wbyte(8'hAA, a); wbyte(8'hFF, a); wbyte(8'hFF, a);
        wbyte(8'h5A, a); wbyte(8'hA5, a); i2c_stop; wq(4);
        chk("R11 wrap addresses", {we_log[w0], we_log[w0 + 1]}, {14'h3FFF, 14'h0000});
        chk("R11 wrap data", {mem[63], mem[0]}, 16'h5AA5);
    endtask

    initial begin
        t_reset;
        t_no_start;
        t_match;
        t_write;
        t_busy;
        t_read;
        t_wp;
        t_wrap;
        chk("R12 oe moved only with clock low", viol, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule